// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two pulse trains of an incremental encoder into signed count events and accumulates them in a 32-bit position register. The register wraps within a software-set ceiling, so it can track a rotating shaft as an angle (0 to ceiling) and not only as a free-running sum. Four count sources are available: full quadrature decoding, pulse plus direction, up-only and down-only. The last two can count either rising edges alone or both edges of input A.

Software reaches the block through a small synchronous register port with a one-cycle registered read path. The block sets an overflow flag when the count wraps past the ceiling and an underflow flag when it wraps below zero. Each flag has an enable bit and a write-1-to-clear bit. An enabled event also sets a summary flag, and that summary flag drives the single interrupt line.

The encoder inputs are asynchronous. Each passes through a two-stage synchronizer before its edges are detected, so a change on A or B reaches the position register three clock edges later.

Top module: `qdec_counter`

## Requirements
- R1: Register 2 (configuration) bits 15:14 select the count source: 00 quadrature, 01 pulse/direction, 10 up-only, 11 down-only. Reset value is 0.
- R2: In quadrature mode, every step in which exactly one of A, B changes counts once. The sequence {A,B} = 00→10→11→01→00 counts up and the reverse sequence counts down. A step in which A and B change together does not count.
- R3: In pulse/direction mode, only a rising edge of A counts. It counts up while B is 1 and down while B is 0. A falling edge of A does not count.
- R4: In up-only and down-only modes, B has no effect. With configuration bit 11 clear, only rising edges of A count. With it set, both edges of A count.
- R5: Counting up while the position is at or above the ceiling (register 1) loads 0 and sets the overflow flag, bit 6 of register 5.
- R6: Counting down while the position is 0 loads the ceiling and sets the underflow flag, bit 5 of register 5.
- R7: Register 3 bit 3 enables counting. While that bit is clear, the position holds its value whatever A and B do.
- R8: Register 4 bits 6 and 5 enable the overflow and underflow events. An enabled event sets the summary flag (register 5 bit 0) and asserts irq. A masked event still sets its own flag but leaves irq low.
- R9: Writing 1 to a bit of register 6 clears the flag at the same bit position of register 5. irq stays high until bit 0 is cleared, even after the event flags are cleared.
- R10: A write to register 0 loads the position directly. A new ceiling written to register 1 governs the next count event.
- R11: After reset, the position is 0, the ceiling is all ones, all flags are 0 and irq is 0. Read data appears one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder input A (asynchronous) |
| enc_b | input | 1 | Encoder input B (asynchronous) |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, held until summary flag cleared |

## Verification
The quadrature decoder is first driven through the forward Gray sequence and then the reverse one, which shows that the phase order alone sets the direction. A diagonal step with both inputs changing together then shows that illegal transitions are rejected. Pulse/direction mode is driven with A pulses at each level of B, and the up and down modes are driven with and without both-edge clocking while B toggles, which separates edge selection from the role of B. A small ceiling loaded through the counter register forces wraps in both directions, with the event enables first masked and then set, to show how flags, the summary flag and irq depend on each other under write-1-to-clear.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD = 2'b00,
    SRC_PDIR = 2'b01,
    SRC_UP   = 2'b10,
    SRC_DOWN = 2'b11
  } src_mode_e;

  localparam int MODE_HI  = 15;
  localparam int MODE_LO  = 14;
  localparam int BOTHEDGE = 11;
  localparam int RUN_BIT  = 3;
  localparam int OVF_BIT  = 6;
  localparam int UNF_BIT  = 5;
  localparam int SUM_BIT  = 0;

  localparam logic [2:0] A_POS  = 3'd0;
  localparam logic [2:0] A_CEIL = 3'd1;
  localparam logic [2:0] A_CFG  = 3'd2;
  localparam logic [2:0] A_RUN  = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;
  localparam logic [2:0] A_FLG  = 3'd5;
  localparam logic [2:0] A_CLR  = 3'd6;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      a_s,
  input  logic      b_s,
  input  src_mode_e mode,
  input  logic      both_edge,
  output logic      evt,
  output logic      up
);
  logic a_p, b_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_p <= 1'b0;
      b_p <= 1'b0;
    end else begin
      a_p <= a_s;
      b_p <= b_s;
    end
  end

  logic a_chg, b_chg, a_rise;
  assign a_chg  = a_s ^ a_p;
  assign b_chg  = b_s ^ b_p;
  assign a_rise = a_s & ~a_p;

  always_comb begin
    evt = 1'b0;
    up  = 1'b1;
    unique case (mode)
      SRC_QUAD: begin
        evt = a_chg ^ b_chg;
        up  = a_chg ? (a_s != b_s) : (b_s == a_s);
      end
      SRC_PDIR: begin
        evt = a_rise;
        up  = b_s;
      end
      SRC_UP: begin
        evt = both_edge ? a_chg : a_rise;
        up  = 1'b1;
      end
      SRC_DOWN: begin
        evt = both_edge ? a_chg : a_rise;
        up  = 1'b0;
      end
      default: ;
    endcase
  end

  // R2: a diagonal step never yields a count
  assert_no_diag_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == SRC_QUAD && a_chg && b_chg) |-> !evt);
  // R3: a falling A edge is silent in pulse/direction mode
  assert_pdir_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == SRC_PDIR && a_p && !a_s) |-> !evt);
endmodule

// File: rtl/qdec_position.sv
module qdec_position #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         evt,
  input  logic         up,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] ceil,
  output logic [W-1:0] pos,
  output logic         ovf_p,
  output logic         unf_p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      ovf_p <= 1'b0;
      unf_p <= 1'b0;
    end else begin
      ovf_p <= 1'b0;
      unf_p <= 1'b0;
      if (load) begin
        pos <= load_val;
      end else if (run && evt) begin
        if (up) begin
          if (pos >= ceil) begin
            pos   <= '0;
            ovf_p <= 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end else begin
          if (pos == '0) begin
            pos   <= ceil;
            unf_p <= 1'b1;
          end else begin
            pos <= pos - 1'b1;
          end
        end
      end
    end
  end

  // R7: stopped counter holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(pos));
  // R5: upward wrap lands on zero with an overflow pulse
  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (rst)
    (run && evt && up && !load && pos >= ceil) |=> (pos == '0 && ovf_p));
  // R6: downward wrap lands on the old ceiling with an underflow pulse
  assert_wrap_dn_R6: assert property (@(posedge clk) disable iff (rst)
    (run && evt && !up && !load && pos == '0) |=> (pos == $past(ceil) && unf_p));
  assert_one_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    !(ovf_p && unf_p));
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int CTRL_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int PADW = CNT_W - CTRL_W;

  logic [CTRL_W-1:0] cfg_r, run_r, ien_r, flg_r;
  logic [CNT_W-1:0]  ceil_r, pos;
  logic [1:0]        ab_s;
  logic              evt, up, ovf_p, unf_p;

  qdec_sync #(.N(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din({enc_a, enc_b}), .dout(ab_s));

  qdec_decode u_dec (
    .clk(clk), .rst(rst), .a_s(ab_s[1]), .b_s(ab_s[0]),
    .mode(src_mode_e'(cfg_r[MODE_HI:MODE_LO])), .both_edge(cfg_r[BOTHEDGE]),
    .evt(evt), .up(up));

  logic wr_pos, wr_clr;
  assign wr_pos = bus_we && bus_addr == A_POS;
  assign wr_clr = bus_we && bus_addr == A_CLR;

  qdec_position #(.W(CNT_W)) u_pos (
    .clk(clk), .rst(rst), .run(run_r[RUN_BIT]), .evt(evt), .up(up),
    .load(wr_pos), .load_val(bus_wdata), .ceil(ceil_r),
    .pos(pos), .ovf_p(ovf_p), .unf_p(unf_p));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_r  <= '0;
      run_r  <= '0;
      ien_r  <= '0;
      ceil_r <= '1;
    end else if (bus_we) begin
      unique case (bus_addr)
        A_CEIL: ceil_r <= bus_wdata;
        A_CFG:  cfg_r  <= bus_wdata[CTRL_W-1:0];
        A_RUN:  run_r  <= bus_wdata[CTRL_W-1:0];
        A_IEN:  ien_r  <= bus_wdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  logic [CTRL_W-1:0] set_v, clr_v;
  always_comb begin
    set_v = '0;
    set_v[OVF_BIT] = ovf_p;
    set_v[UNF_BIT] = unf_p;
    set_v[SUM_BIT] = (ovf_p & ien_r[OVF_BIT]) | (unf_p & ien_r[UNF_BIT]);
    clr_v = wr_clr ? bus_wdata[CTRL_W-1:0] : '0;
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (rst) flg_r <= '0;
    else     flg_r <= (flg_r & ~clr_v) | set_v;
  end

  assign irq = flg_r[SUM_BIT];

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        A_POS:  bus_rdata <= pos;
        A_CEIL: bus_rdata <= ceil_r;
        A_CFG:  bus_rdata <= {{PADW{1'b0}}, cfg_r};
        A_RUN:  bus_rdata <= {{PADW{1'b0}}, run_r};
        A_IEN:  bus_rdata <= {{PADW{1'b0}}, ien_r};
        A_FLG:  bus_rdata <= {{PADW{1'b0}}, flg_r};
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R9: irq persists until the summary bit is written with 1 at the clear address
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wr_clr && bus_wdata[SUM_BIT])) |=> irq);
  // R5: an overflow pulse is visible in the flag register next cycle
  assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_p |=> flg_r[OVF_BIT]);
  // R8: masked events do not raise irq
  assert_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (!irq && !(ovf_p && ien_r[OVF_BIT]) && !(unf_p && ien_r[UNF_BIT])) |=> !irq);
endmodule

// File: tb/qdec_counter_bench.sv
module qdec_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdec_counter u_qdec_counter (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  typedef struct { string tag; logic [31:0] val; } exp_t;
  exp_t exp_q[$];
  logic mon_req = 1'b0;

  // monitor: pops an expected item and compares with the read data
  always @(negedge clk) begin
    if (mon_req) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (bus_rdata !== e.val) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", e.tag, bus_rdata, e.val);
      end
      mon_req = 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a;
    e.tag = tag; e.val = v;
    exp_q.push_back(e);
    @(posedge clk);
    #1 mon_req = 1'b1;
    wait (!mon_req);
  endtask

  task automatic expect_irq(input logic v, input string tag);
    @(negedge clk);
    n_tests++;
    if (irq !== v) begin
      n_fail++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, v);
    end
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R11 reset state
    expect_reg(3'd0, 32'd0, "R11 position after reset");
    expect_reg(3'd1, 32'hFFFF_FFFF, "R11 ceiling after reset");
    expect_reg(3'd5, 32'd0, "R11 flags after reset");
    expect_irq(1'b0, "R11 irq after reset");

    // R7: disabled counter ignores edges
    step(1, 0); step(1, 1);
    expect_reg(3'd0, 32'd0, "R7 hold while disabled");
    step(0, 0);  // diagonal, also disabled
    wr(3'd3, 32'h8);

    // R2 quadrature forward then reverse
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    expect_reg(3'd0, 32'd4, "R2 forward sequence");
    step(0, 1); step(1, 1);
    expect_reg(3'd0, 32'd2, "R2 reverse sequence");
    step(0, 0);
    expect_reg(3'd0, 32'd2, "R2 diagonal step ignored");

    // R1/R3 pulse/direction
    wr(3'd2, 32'h4000);
    expect_reg(3'd2, 32'h4000, "R1 mode field readback");
    step(0, 1); step(1, 1);
    expect_reg(3'd0, 32'd3, "R3 rise with B high counts up");
    step(0, 1);
    expect_reg(3'd0, 32'd3, "R3 falling A ignored");
    step(0, 0); step(1, 0);
    expect_reg(3'd0, 32'd2, "R3 rise with B low counts down");

    // R4 up-only, single then both edges
    wr(3'd2, 32'h8000);
    step(0, 0); step(1, 0); step(1, 1); step(1, 0);
    expect_reg(3'd0, 32'd3, "R4 up single edge, B ignored");
    wr(3'd2, 32'h8800);
    step(0, 0); step(1, 0);
    expect_reg(3'd0, 32'd5, "R4 up both edges");
    wr(3'd2, 32'hC800);
    step(0, 1); step(1, 0);
    expect_reg(3'd0, 32'd3, "R4 down both edges, B ignored");

    // R10 load and ceiling; R5 wrap with event masked
    wr(3'd0, 32'd5);
    wr(3'd1, 32'd6);
    expect_reg(3'd0, 32'd5, "R10 direct load");
    wr(3'd2, 32'h8000);
    step(0, 0); step(1, 0);
    expect_reg(3'd0, 32'd6, "R10 count to ceiling");
    step(0, 0); step(1, 0);
    expect_reg(3'd0, 32'd0, "R5 wrap to zero");
    expect_reg(3'd5, 32'h40, "R5 overflow flag set");
    expect_irq(1'b0, "R8 masked event leaves irq low");
    wr(3'd6, 32'h40);
    expect_reg(3'd5, 32'h0, "R9 overflow flag cleared");

    // R6 underflow with events enabled; R8/R9
    wr(3'd4, 32'h60);
    wr(3'd2, 32'hC000);
    step(0, 0); step(1, 0);
    expect_reg(3'd0, 32'd6, "R6 wrap to ceiling");
    expect_reg(3'd5, 32'h21, "R6 underflow and summary flags");
    expect_irq(1'b1, "R8 enabled event asserts irq");
    wr(3'd6, 32'h20);
    expect_irq(1'b1, "R9 irq held after event flag clear");
    wr(3'd6, 32'h01);
    expect_irq(1'b0, "R9 irq released by summary clear");
    expect_reg(3'd5, 32'h0, "R9 all flags clear");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule